// File: doc/BRIEF.md
# Serial Converter Port with DSP Framing

This block is the device-side digital port of a multichannel serial analog-to-digital converter. It runs from the serial clock supplied by the host, takes in an 8-bit command, marks the acquisition window and the sampling instant, and returns the 16-bit result MSB first on a single data line. The converter itself is not part of the block. A `sample_value` input stands in for its output, and the `sample_strobe` output marks the moment the value is captured.

Each frame opens when chip select falls. At that edge the port latches two choices. `dsp_req` selects the interface style: the SPI-compatible style, or the DSP style, which adds a one-clock frame-sync pulse and launches data on rising clock edges. `wide_sel` selects the transfer width. The wide width lengthens acquisition by eight clocks. Raising chip select at any time ends the frame, puts the data line into high impedance and makes the block ready for the next frame.

Clocks are numbered from the falling edge of chip select: clock k is the k-th rising SCLK edge. The sampling clock S is 8 for SPI narrow, 16 for SPI wide, 15 for DSP narrow and 23 for DSP wide.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, with `cs_n` high, `dout_oe`, `dout`, `frame_sync`, `sample_strobe`, `acq_window` and `cmd_valid` are all 0.
- R2: On the falling edge of `cs_n`, `dsp_req` = 1 selects SPI style and 0 selects DSP style, and `wide_sel` = 1 selects wide transfers and 0 selects narrow ones. Changes to either input later in the frame have no effect.
- R3: `din` is taken on rising clocks 1 to 8, MSB first, into `cmd_byte`. `cmd_valid` rises after clock 8 and stays high, with `cmd_byte` unchanged, until `cs_n` rises.
- R4: `sample_strobe` is high for exactly the one period that follows rising clock S. `sample_value` is captured on that edge, and later changes to it do not alter the shifted result.
- R5: `acq_window` is high from rising clock 4 until rising clock S.
- R6: In SPI style the result MSB is launched on the falling edge of clock S, with one further bit on each later falling edge. A narrow SPI frame therefore delivers its command and all 16 result bits within 24 clocks, which is three 8-bit transfers.
- R7: In DSP style `frame_sync` is high for exactly one period, starting at rising clock S+1 (clock 16 when narrow). The result MSB is launched on rising clock S+2 (clock 17 when narrow), with one bit on each later rising edge.
- R8: After the 16 result bits have been shifted out, further clocks with `cs_n` low shift out 0.
- R9: Whenever `cs_n` is high, `dout_oe` is 0 and `dout` reads 0.
- R10: Raising `cs_n` in mid-frame drops `cmd_valid`, `frame_sync`, `sample_strobe` and `acq_window`. The next frame counts again from clock 1.
- R11: `frame_sync` never rises in SPI style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; its falling edge opens a frame |
| din | input | 1 | Serial command input |
| dsp_req | input | 1 | Style select, latched at `cs_n` fall (1 = SPI, 0 = DSP) |
| wide_sel | input | 1 | Width select, latched at `cs_n` fall (1 = wide) |
| sample_value | input | 16 | Converter result stub |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| frame_sync | output | 1 | DSP-style frame-sync pulse |
| sample_strobe | output | 1 | Marks the sampling instant |
| acq_window | output | 1 | High during acquisition |
| cmd_byte | output | 8 | Captured command |
| cmd_valid | output | 1 | `cmd_byte` is complete for this frame |

## Verification
The properties assume that `cs_n` stays high for at least one full SCLK period between frames. They also assume that `dsp_req`, `wide_sel` and `cs_n` change only while SCLK is low, so that no capture edge coincides with a clock edge. The directed stimulus opens and closes each frame a fixed interval after a falling clock edge, and it keeps chip select high across several clocks between frames. It toggles the style and width inputs in mid-frame only to show that they are ignored. Each frame runs past the last result bit, so the zero fill is observed as well.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  typedef enum logic {
    PORT_SPI = 1'b0,
    PORT_DSP = 1'b1
  } port_mode_e;
endpackage

// File: rtl/adcsp_frame_timer.sv
// Counts rising SCLK edges since chip select fell and decodes the frame points.
module adcsp_frame_timer
  import adcsp_pkg::*;
#(
  parameter int CMD_BITS   = 8,
  parameter int SPI_SAMPLE = 8,
  parameter int DSP_SAMPLE = 15,
  parameter int WIDE_EXTRA = 8,
  parameter int ACQ_FIRST  = 4,
  parameter int CNT_W      = 6
) (
  input  logic       sclk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  port_mode_e mode,
  input  logic       wide,
  output logic       cmd_en,
  output logic       cmd_done,
  output logic       load_en,
  output logic       shift_en,
  output logic       launch_en,
  output logic       strobe,
  output logic       sync,
  output logic       acq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SPI_PT  = CNT_W'(SPI_SAMPLE);
  localparam logic [CNT_W-1:0] DSP_PT  = CNT_W'(DSP_SAMPLE);
  localparam logic [CNT_W-1:0] EXTRA   = CNT_W'(WIDE_EXTRA);
  localparam logic [CNT_W-1:0] ACQ_PT  = CNT_W'(ACQ_FIRST);
  localparam logic [CNT_W-1:0] CMD_PT  = CNT_W'(CMD_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] sample_pt, sync_pt;

  always_comb begin
    cnt_en = (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cs_n)   cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    sample_pt = ((mode == PORT_DSP) ? DSP_PT : SPI_PT) + (wide ? EXTRA : '0);
    sync_pt   = sample_pt + 1'b1;
    cmd_en    = (cnt_q < CMD_PT);
    cmd_done  = (cnt_q >= CMD_PT);
    load_en   = (cnt_q == sample_pt - 1'b1);
    launch_en = (cnt_q >= sample_pt);
    shift_en  = (mode == PORT_DSP) ? (cnt_q >= sync_pt) : (cnt_q >= sample_pt);
    strobe    = (cnt_q == sample_pt);
    sync      = (mode == PORT_DSP) && (cnt_q == sync_pt);
    acq       = (cnt_q >= ACQ_PT) && (cnt_q < sample_pt);
  end
endmodule

// File: rtl/adcsp_cmd_capture.sv
// Shifts the command in MSB first on rising SCLK.
module adcsp_cmd_capture #(
  parameter int CMD_BITS = 8
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                din,
  output logic [CMD_BITS-1:0] cmd
);
  logic [CMD_BITS-1:0] cmd_d;

  always_comb cmd_d = {cmd[CMD_BITS-2:0], din};

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)        cmd <= '0;
    else if (shift_en) cmd <= cmd_d;
  end
endmodule

// File: rtl/adcsp_result_shifter.sv
// Holds the captured result and launches it on the edge chosen by the style.
module adcsp_result_shifter
  import adcsp_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  port_mode_e           mode,
  input  logic                 load_en,
  input  logic                 shift_en,
  input  logic                 launch_en,
  input  logic [DATA_BITS-1:0] sample_value,
  output logic                 dout_bit
);
  logic [DATA_BITS-1:0] sr_q, sr_d;
  logic                 sr_en;
  logic                 rise_q, fall_q;
  logic                 rise_en, fall_en;

  always_comb begin
    sr_en   = load_en | shift_en;
    sr_d    = load_en ? sample_value : {sr_q[DATA_BITS-2:0], 1'b0};
    rise_en = (mode == PORT_DSP) && shift_en;
    fall_en = (mode == PORT_SPI) && launch_en;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  // DSP style: launch on the rising edge
  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)       rise_q <= 1'b0;
    else if (cs_n)    rise_q <= 1'b0;
    else if (rise_en) rise_q <= sr_q[DATA_BITS-1];
  end

  // SPI style: launch on the falling edge
  always_ff @(negedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)       fall_q <= 1'b0;
    else if (cs_n)    fall_q <= 1'b0;
    else if (fall_en) fall_q <= sr_q[DATA_BITS-1];
  end

  always_comb dout_bit = (mode == PORT_DSP) ? rise_q : fall_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adcsp_pkg::*;
#(
  parameter int CMD_BITS   = 8,
  parameter int DATA_BITS  = 16,
  parameter int SPI_SAMPLE = 8,
  parameter int DSP_SAMPLE = 15,
  parameter int WIDE_EXTRA = 8,
  parameter int ACQ_FIRST  = 4
) (
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 din,
  input  logic                 dsp_req,
  input  logic                 wide_sel,
  input  logic [DATA_BITS-1:0] sample_value,
  output logic                 dout,
  output logic                 dout_oe,
  output logic                 frame_sync,
  output logic                 sample_strobe,
  output logic                 acq_window,
  output logic [CMD_BITS-1:0]  cmd_byte,
  output logic                 cmd_valid
);
  localparam int CNT_W = $clog2(DSP_SAMPLE + WIDE_EXTRA + DATA_BITS + 4);

  port_mode_e mode_q;
  logic       wide_q;
  logic       dsp_active;
  logic       cmd_en, cmd_done, load_en, shift_en, launch_en;
  logic       strobe, sync, acq, dout_bit;

  // Style and width are latched on the falling edge of chip select (R2)
  always_ff @(negedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PORT_SPI;
      wide_q <= 1'b0;
    end else begin
      mode_q <= dsp_req ? PORT_SPI : PORT_DSP;
      wide_q <= wide_sel;
    end
  end

  adcsp_frame_timer #(
    .CMD_BITS  (CMD_BITS),
    .SPI_SAMPLE(SPI_SAMPLE),
    .DSP_SAMPLE(DSP_SAMPLE),
    .WIDE_EXTRA(WIDE_EXTRA),
    .ACQ_FIRST (ACQ_FIRST),
    .CNT_W     (CNT_W)
  ) u_timer (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .mode     (mode_q),
    .wide     (wide_q),
    .cmd_en   (cmd_en),
    .cmd_done (cmd_done),
    .load_en  (load_en),
    .shift_en (shift_en),
    .launch_en(launch_en),
    .strobe   (strobe),
    .sync     (sync),
    .acq      (acq)
  );

  adcsp_cmd_capture #(
    .CMD_BITS(CMD_BITS)
  ) u_cmd (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .shift_en(cmd_en & ~cs_n),
    .din     (din),
    .cmd     (cmd_byte)
  );

  adcsp_result_shifter #(
    .DATA_BITS(DATA_BITS)
  ) u_shift (
    .sclk        (sclk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .mode        (mode_q),
    .load_en     (load_en),
    .shift_en    (shift_en),
    .launch_en   (launch_en),
    .sample_value(sample_value),
    .dout_bit    (dout_bit)
  );

  always_comb begin
    dsp_active    = (mode_q == PORT_DSP);
    dout_oe       = rst_n & ~cs_n;
    dout          = dout_oe & dout_bit;
    frame_sync    = ~cs_n & sync;
    sample_strobe = ~cs_n & strobe;
    acq_window    = ~cs_n & acq;
    cmd_valid     = ~cs_n & cmd_done;
  end
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int CMD_BITS = 8
) (
  input logic                sclk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                dout_oe,
  input logic                frame_sync,
  input logic                sample_strobe,
  input logic                acq_window,
  input logic                cmd_valid,
  input logic [CMD_BITS-1:0] cmd_byte,
  input logic                dsp_active
);
  // R9
  idle_outputs_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> (!dout_oe && !frame_sync && !cmd_valid && !sample_strobe));

  // R7
  sync_one_period_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    frame_sync |=> !frame_sync);

  // R4
  strobe_one_period_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);

  // R7
  sync_after_sample_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(frame_sync) |-> $past(sample_strobe));

  // R5
  acq_before_sample_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(sample_strobe) |-> $past(acq_window));

  // R11
  sync_dsp_only_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    frame_sync |-> dsp_active);

  // R3
  cmd_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cmd_valid |=> $stable(cmd_byte));
endmodule

bind adc_serial_port adc_serial_port_chk #(.CMD_BITS(CMD_BITS)) u_chk (
  .sclk         (sclk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .dout_oe      (dout_oe),
  .frame_sync   (frame_sync),
  .sample_strobe(sample_strobe),
  .acq_window   (acq_window),
  .cmd_valid    (cmd_valid),
  .cmd_byte     (cmd_byte),
  .dsp_active   (dsp_active)
);

// File: tb/tb_adc_serial_port.sv
`timescale 1ns/1ps
module tb_adc_serial_port;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        dsp_req = 1'b1;
  logic        wide_sel = 1'b0;
  logic [15:0] sample_value = '0;
  logic        dout, dout_oe, frame_sync, sample_strobe, acq_window, cmd_valid;
  logic [7:0]  cmd_byte;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 sclk = ~sclk;

  adc_serial_port dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .dsp_req(dsp_req),
    .wide_sel(wide_sel), .sample_value(sample_value), .dout(dout),
    .dout_oe(dout_oe), .frame_sync(frame_sync), .sample_strobe(sample_strobe),
    .acq_window(acq_window), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req);
    chk(dout_oe == 1'b0 && dout == 1'b0, req, {30'd0, dout_oe, dout}, 32'd0);
    chk(frame_sync == 1'b0 && sample_strobe == 1'b0 && acq_window == 1'b0 &&
        cmd_valid == 1'b0, req,
        {28'd0, frame_sync, sample_strobe, acq_window, cmd_valid}, 32'd0);
  endtask

  // One frame; dsp selects DSP style, wide the wide width; nclk rising edges.
  task automatic run_frame(input bit dsp, input bit wide, input logic [7:0] cmd,
                           input logic [15:0] val, input int nclk);
    int s;
    int bad_strobe = 0, bad_sync = 0, bad_acq = 0, bad_oe = 0, bad_data = 0;
    int bad_zero = 0, n_sync = 0;
    s = dsp ? (wide ? 23 : 15) : (wide ? 16 : 8);
    sample_value = val;
    @(negedge sclk);
    dsp_req  = ~dsp;
    wide_sel = wide;
    #1 cs_n = 1'b0;
    for (int k = 1; k <= nclk; k++) begin
      din = (k <= 8) ? cmd[8-k] : 1'b0;
      if (k == 5) begin            // R2: mid-frame changes are ignored
        dsp_req  = dsp;
        wide_sel = ~wide;
      end
      @(posedge sclk); #2;
      if (sample_strobe != (k == s)) bad_strobe++;
      if (frame_sync != (dsp && k == s + 1)) bad_sync++;
      if (frame_sync) n_sync++;
      if (acq_window != (k >= 4 && k < s)) bad_acq++;
      if (!dout_oe) bad_oe++;
      if (k == 8)
        chk(cmd_valid && cmd_byte == cmd, "R3 command capture", {23'd0, cmd_valid, cmd_byte},
            {23'd1, cmd});
      if (k == s) sample_value = ~val;   // R4: late change must not matter
      if (dsp && k >= s + 2) begin
        int bp = 15 - (k - s - 2);
        if (bp >= 0) begin
          if (dout != val[bp]) bad_data++;
        end else if (dout != 1'b0) bad_zero++;
      end
      @(negedge sclk); #2;
      if (!dsp && k >= s) begin
        int bp = 15 - (k - s);
        if (bp >= 0) begin
          if (dout != val[bp]) bad_data++;
        end else if (dout != 1'b0) bad_zero++;
      end
    end
    cs_n = 1'b1;
    chk(bad_strobe == 0, "R4 strobe only after clock S", bad_strobe, 0);
    chk(bad_acq == 0, "R5 acquisition window", bad_acq, 0);
    chk(bad_oe == 0, "R9 output enabled in frame", bad_oe, 0);
    chk(bad_zero == 0, "R8 zero fill", bad_zero, 0);
    if (dsp) begin
      chk(bad_sync == 0 && n_sync == 1, "R7 single frame sync at S+1", n_sync, 1);
      chk(bad_data == 0, "R7 DSP rising-edge data and R2 latched mode", bad_data, 0);
    end else begin
      chk(n_sync == 0, "R11 no frame sync in SPI style", n_sync, 0);
      chk(bad_data == 0, "R6 SPI falling-edge data and R2 latched mode", bad_data, 0);
    end
    #1 idle_check("R9 idle after frame");
    repeat (3) @(negedge sclk);
  endtask

  task automatic t_reset;
    #1 idle_check("R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge sclk);
    #1 idle_check("R1 idle after reset release");
  endtask

  task automatic t_abort;
    @(negedge sclk);
    dsp_req  = 1'b0;
    wide_sel = 1'b0;
    #1 cs_n = 1'b0;
    repeat (12) @(posedge sclk);
    #2 chk(acq_window == 1'b1 && cmd_valid == 1'b1, "R10 frame underway",
           {30'd0, acq_window, cmd_valid}, 32'd3);
    cs_n = 1'b1;
    #1 idle_check("R10 abort returns to idle");
    repeat (4) @(posedge sclk);
    #2 idle_check("R9 idle with clocks running");
    repeat (2) @(negedge sclk);
    run_frame(1'b0, 1'b0, 8'h3C, 16'hBEEF, 27);   // R10 restart from clock 1
  endtask

  initial begin
    t_reset();
    run_frame(1'b0, 1'b0, 8'hA5, 16'h8001, 27);   // R6 SPI narrow, 24 clocks + fill
    run_frame(1'b0, 1'b1, 8'h5A, 16'h1234, 34);   // SPI wide
    run_frame(1'b1, 1'b0, 8'hC3, 16'hF00F, 36);   // R7 DSP narrow
    run_frame(1'b1, 1'b1, 8'h81, 16'h6A59, 44);   // DSP wide
    t_abort();
    run_frame(1'b1, 1'b0, 8'hFF, 16'h0000, 34);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule